// File: doc/BRIEF.md
# Serial Configuration Port

This block is a serial slave that lets a host read and write a small byte-wide register file over four wires: an active-low select, a serial clock, a data line that carries data both ways, and a second data line used only for output. The pad buffers sit outside the block, so each data line appears as a data value plus an output enable, with the input line coming in separately. Serial clock and select are brought into the system clock domain through synchronizers and sampled there, so the serial clock must run several times slower than the system clock.

A transfer opens with a 16-bit instruction that gives the direction, the byte count and the start address. Data bytes follow. After each byte the address steps down when bits travel MSB-first and up when they travel LSB-first. Address 0x00 is the port's own configuration byte. Each control bit in it is held twice, in bit-reversed nibbles, so the host can write it correctly whichever bit order it assumes. Writing the soft-reset bit returns every register to its default. The counter and monitor fields are brought out as ports for the logic that uses them.

Top module: `cfg_serial_port`

## Requirements
- R1: The 16-bit instruction has three fields. Bit 15 is the direction (1 = read, 0 = write). Bits 14:13 give the byte count (00 = one byte, 01 = two, 10 = three, 11 = stream until select rises). Bits 12:0 give the start address. Input bits are sampled on rising serial-clock edges and read data changes on falling edges.
- R2: When the LSB-first control is 0 (the reset state), every instruction and data bit is shifted most-significant first, and the address decrements after each data byte.
- R3: When the LSB-first control is 1, instruction and data are shifted least-significant first (instruction bit 0 first), and the address increments after each data byte.
- R4: During the data bytes of a read, and only then, exactly one output line is enabled. If the output-pin control is 0, read data goes out on `sdio_o` with `sdio_oe` high and `sdo_oe` low. If it is 1, read data goes out on `sdo_o` with `sdo_oe` high and `sdio_oe` low.
- R5: Raising `cs_n` ends the current transfer. It drops both output enables, discards any partial instruction or byte, and the next transfer starts again with a fresh instruction.
- R6: A write to address 0x00 with bit 2 or bit 5 set returns every register to its default: configuration 0x18, counters 0, monitor byte 0. The reset bit itself always reads back 0.
- R7: Writes to addresses other than 0x00 and 0x04 to 0x07 change nothing, and reads from those addresses return 0x00.
- R8: Configuration byte 0x00 keeps the output-pin control in bits 0 and 7, LSB-first in bits 1 and 6, soft reset in bits 2 and 5, and a fixed 1 in bits 3 and 4. A write sets a control if either of its two copies is 1.
- R9: A change of bit order written during a transfer takes effect at the next transfer. The rest of the current transfer keeps the old bit order and the old address direction.
- R10: Address 0x04 bits 5:0 hold the 6-bit `a_count`. Address 0x05 bits 4:0 hold `b_count[12:8]` and address 0x06 holds `b_count[7:0]`. Unused bits read 0.
- R11: Address 0x07 bit 2 drives `lor_en`. Bits 6:5 select `lock_wait` as 3, 6, 12 or 24 for codes 00 to 11. All other bits of that byte read 0.
- R12: Once a transfer with a byte count of one, two or three has moved that many bytes, further serial clocks in the same transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select; high ends a transfer |
| sck | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Input value of the shared data line |
| sdio_o | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo_o | output | 1 | Read data for the output-only line |
| sdo_oe | output | 1 | Output enable for the output-only line |
| a_count | output | 6 | Counter A value |
| b_count | output | 13 | Counter B value |
| lor_en | output | 1 | Loss-of-reference monitor enable |
| lock_wait | output | 5 | Lock-detect delay in detector cycles |

## Verification
Writes and reads are run in both bit orders, and the byte values are chosen asymmetric, so a reversed bit or byte shows up as a wrong value. Multi-byte transfers with all three fixed counts and with streaming check the direction in which the address steps, and show whether a transfer stops after its count or spills into the next register. Configuration writes that set only one of a control's two copies are used to tell the upper nibble from the lower. A stream that switches bit order partway through its own transfer, and transfers aborted in mid-instruction and mid-read, check that state is latched per transfer and cleared when select rises.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = ADDR_W + 3;
  localparam int CNT_W   = $clog2(INSTR_W + 1);
  localparam int BIDX_W  = $clog2(DATA_W);
  localparam int A_W     = 6;
  localparam int B_W     = 13;
  localparam int BHI_W   = B_W - DATA_W;
  localparam int WAIT_W  = 5;

  localparam logic [ADDR_W-1:0] ADR_CFG = 13'h0000;
  localparam logic [ADDR_W-1:0] ADR_ACNT = 13'h0004;
  localparam logic [ADDR_W-1:0] ADR_BHI = 13'h0005;
  localparam logic [ADDR_W-1:0] ADR_BLO = 13'h0006;
  localparam logic [ADDR_W-1:0] ADR_MON = 13'h0007;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  typedef struct packed {
    phase_e              phase;
    logic [CNT_W-1:0]    bit_cnt;
    logic [INSTR_W-1:0]  sh;
    logic [ADDR_W-1:0]   addr;
    logic                rd;
    logic [1:0]          len;
    logic [1:0]          nbytes;
    logic                lsb;
    logic                load;
    logic [DATA_W-1:0]   tx;
    logic                dout;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [DATA_W-1:0]   wr_data;
  } eng_st_t;

  function automatic logic is_impl(logic [ADDR_W-1:0] a);
    return (a == ADR_CFG) || (a == ADR_ACNT) || (a == ADR_BHI) ||
           (a == ADR_BLO) || (a == ADR_MON);
  endfunction

  function automatic logic [WAIT_W-1:0] wait_of(logic [1:0] code);
    return WAIT_W'(3) << code;
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic rst_sn,
  output logic cs_n_s,
  output logic sck_s,
  output logic sdi_s
);

  localparam logic [2:0] PIN_IDLE = 3'b001;

  logic [STAGES-1:0]      rst_pipe;
  logic [STAGES-1:0][2:0] pin_pipe;

  // reset: asserted at once, released after STAGES clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_pipe <= {STAGES{PIN_IDLE}};
    else        pin_pipe <= {pin_pipe[STAGES-2:0], {sdi_i, sck_i, cs_n_i}};
  end

  assign rst_sn = rst_pipe[STAGES-1];
  assign cs_n_s = pin_pipe[STAGES-1][0];
  assign sck_s  = pin_pipe[STAGES-1][1];
  assign sdi_s  = pin_pipe[STAGES-1][2];

endmodule

// File: rtl/scp_engine.sv
module scp_engine
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              cfg_lsb,
  input  logic              cfg_sdo,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              sdio_oe,
  output logic              sdo_oe
);

  eng_st_t st, nx;
  logic    sck_q;
  logic    cs_act, rise, fall, rd_active;
  logic [DATA_W-1:0] byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign cs_act = !cs_n_s;
  assign rise   = cs_act && sck_s && !sck_q;
  assign fall   = cs_act && !sck_s && sck_q;

  // next-state logic
  always_comb begin
    nx       = st;
    nx.wr_en = 1'b0;
    nx.load  = 1'b0;
    byte_in  = '0;
    if (st.load) nx.tx = rd_data;
    if (!cs_act) begin
      nx.phase   = PH_INSTR;
      nx.bit_cnt = '0;
      nx.rd      = 1'b0;
      nx.lsb     = cfg_lsb;
    end else if (rise) begin
      nx.sh      = st.lsb ? {sdi_s, st.sh[INSTR_W-1:1]} : {st.sh[INSTR_W-2:0], sdi_s};
      nx.bit_cnt = st.bit_cnt + 1'b1;
      byte_in    = st.lsb ? nx.sh[INSTR_W-1 -: DATA_W] : nx.sh[DATA_W-1:0];
      unique case (st.phase)
        PH_INSTR: begin
          if (st.bit_cnt == CNT_W'(INSTR_W - 1)) begin
            nx.rd      = nx.sh[INSTR_W-1];
            nx.len     = nx.sh[INSTR_W-2 -: 2];
            nx.addr    = nx.sh[ADDR_W-1:0];
            nx.phase   = PH_DATA;
            nx.bit_cnt = '0;
            nx.nbytes  = '0;
            nx.load    = nx.sh[INSTR_W-1];
          end
        end
        PH_DATA: begin
          if (st.bit_cnt == CNT_W'(DATA_W - 1)) begin
            nx.wr_en   = !st.rd;
            nx.wr_addr = st.addr;
            nx.wr_data = byte_in;
            nx.addr    = st.lsb ? st.addr + 1'b1 : st.addr - 1'b1;
            nx.bit_cnt = '0;
            nx.nbytes  = st.nbytes + 1'b1;
            if (st.len != 2'b11 && st.nbytes == st.len) nx.phase = PH_DONE;
            else                                        nx.load  = st.rd;
          end
        end
        default: nx.bit_cnt = st.bit_cnt;
      endcase
    end else if (fall && st.phase == PH_DATA && st.rd) begin
      nx.dout = st.lsb ? st.tx[st.bit_cnt[BIDX_W-1:0]]
                       : st.tx[BIDX_W'(DATA_W - 1) - st.bit_cnt[BIDX_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= nx;
  end

  assign rd_active = cs_act && st.rd && (st.phase == PH_DATA);
  assign sdio_oe   = rd_active && !cfg_sdo;
  assign sdo_oe    = rd_active && cfg_sdo;
  assign dout      = st.dout;
  assign rd_addr   = st.addr;
  assign wr_en     = st.wr_en;
  assign wr_addr   = st.wr_addr;
  assign wr_data   = st.wr_data;

  // R4: never two drivers at once
  a_r4_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe));

  // R5: select high releases both lines on the next cycle
  a_r5_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (!sdio_oe && !sdo_oe));

  // R9: bit order frozen while select stays low
  a_r9_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && $past(!cs_n_s)) |-> $stable(st.lsb));

  // R12: one write strobe per byte
  a_r12_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter logic [A_W-1:0] A_RST   = '0,
  parameter logic [B_W-1:0] B_RST   = '0,
  parameter logic           LOR_RST = 1'b0,
  parameter logic [1:0]     SEL_RST = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cfg_lsb,
  output logic              cfg_sdo,
  output logic [A_W-1:0]    a_count,
  output logic [B_W-1:0]    b_count,
  output logic              lor_en,
  output logic [1:0]        lock_sel
);

  localparam int HALF = DATA_W / 2;

  logic             lsb_q, sdo_q, lor_q;
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [1:0]       sel_q;
  logic             lsb_nx, sdo_nx, lor_nx;
  logic [A_W-1:0]   a_nx;
  logic [B_W-1:0]   b_nx;
  logic [1:0]       sel_nx;
  logic [HALF-1:0]  cfg_set, cfg_lo;
  logic [DATA_W-1:0] cfg_byte;

  // mirrored nibble: bit i and bit 7-i carry the same control
  assign cfg_lo = {1'b1, 1'b0, lsb_q, sdo_q};
  for (genvar i = 0; i < HALF; i++) begin : g_mirror
    assign cfg_set[i]             = wr_data[i] | wr_data[DATA_W-1-i];
    assign cfg_byte[i]            = cfg_lo[i];
    assign cfg_byte[DATA_W-1-i]   = cfg_lo[i];
  end

  always_comb begin
    lsb_nx = lsb_q;
    sdo_nx = sdo_q;
    a_nx   = a_q;
    b_nx   = b_q;
    lor_nx = lor_q;
    sel_nx = sel_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADR_CFG: begin
          if (cfg_set[2]) begin
            lsb_nx = 1'b0;
            sdo_nx = 1'b0;
            a_nx   = A_RST;
            b_nx   = B_RST;
            lor_nx = LOR_RST;
            sel_nx = SEL_RST;
          end else begin
            sdo_nx = cfg_set[0];
            lsb_nx = cfg_set[1];
          end
        end
        ADR_ACNT: a_nx = wr_data[A_W-1:0];
        ADR_BHI:  b_nx = {wr_data[BHI_W-1:0], b_q[DATA_W-1:0]};
        ADR_BLO:  b_nx = {b_q[B_W-1:DATA_W], wr_data};
        ADR_MON: begin
          lor_nx = wr_data[2];
          sel_nx = wr_data[6:5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
      sdo_q <= 1'b0;
      a_q   <= A_RST;
      b_q   <= B_RST;
      lor_q <= LOR_RST;
      sel_q <= SEL_RST;
    end else begin
      lsb_q <= lsb_nx;
      sdo_q <= sdo_nx;
      a_q   <= a_nx;
      b_q   <= b_nx;
      lor_q <= lor_nx;
      sel_q <= sel_nx;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADR_CFG:  rd_data = cfg_byte;
      ADR_ACNT: rd_data = {{(DATA_W-A_W){1'b0}}, a_q};
      ADR_BHI:  rd_data = {{(DATA_W-BHI_W){1'b0}}, b_q[B_W-1:DATA_W]};
      ADR_BLO:  rd_data = b_q[DATA_W-1:0];
      ADR_MON:  rd_data = {1'b0, sel_q, 2'b00, lor_q, 2'b00};
      default:  rd_data = '0;
    endcase
  end

  assign cfg_lsb  = lsb_q;
  assign cfg_sdo  = sdo_q;
  assign a_count  = a_q;
  assign b_count  = b_q;
  assign lor_en   = lor_q;
  assign lock_sel = sel_q;

  // R6: soft reset restores every default
  a_r6_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CFG && (wr_data[2] || wr_data[5])) |=>
    (a_q == A_RST && b_q == B_RST && lor_q == LOR_RST && sel_q == SEL_RST &&
     !lsb_q && !sdo_q));

  // R7: writes to unimplemented addresses change nothing
  a_r7_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_impl(wr_addr)) |=> $stable({lsb_q, sdo_q, a_q, b_q, lor_q, sel_q}));

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic [A_W-1:0]    a_count,
  output logic [B_W-1:0]    b_count,
  output logic              lor_en,
  output logic [WAIT_W-1:0] lock_wait
);

  logic              rst_sn, cs_n_s, sck_s, sdi_s;
  logic              cfg_lsb, cfg_sdo, wr_en, dout;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [1:0]        lock_sel;

  scp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_i (cs_n),
    .sck_i  (sck),
    .sdi_i  (sdio_i),
    .rst_sn (rst_sn),
    .cs_n_s (cs_n_s),
    .sck_s  (sck_s),
    .sdi_s  (sdi_s)
  );

  scp_engine i_engine (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cs_n_s  (cs_n_s),
    .sck_s   (sck_s),
    .sdi_s   (sdi_s),
    .cfg_lsb (cfg_lsb),
    .cfg_sdo (cfg_sdo),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dout    (dout),
    .sdio_oe (sdio_oe),
    .sdo_oe  (sdo_oe)
  );

  scp_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_lsb  (cfg_lsb),
    .cfg_sdo  (cfg_sdo),
    .a_count  (a_count),
    .b_count  (b_count),
    .lor_en   (lor_en),
    .lock_sel (lock_sel)
  );

  assign sdio_o    = dout;
  assign sdo_o     = dout;
  assign lock_wait = wait_of(lock_sel);

endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;

  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, sdio_i;
  logic        sdio_o, sdio_oe, sdo_o, sdo_oe, lor_en;
  logic [5:0]  a_count;
  logic [12:0] b_count;
  logic [4:0]  lock_wait;

  int tests = 0;
  int fails = 0;
  bit lsb_mode = 0;
  bit sdo_mode = 0;

  always #2 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .a_count(a_count), .b_count(b_count), .lor_en(lor_en), .lock_wait(lock_wait)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit slot; returns {sdo_oe, sdo_o, sdio_oe, sdio_o} seen before the rising edge
  task automatic slot(input logic din, output logic [3:0] pv);
    sdio_i = din;
    clk_n(HP);
    pv  = {sdo_oe, sdo_o, sdio_oe, sdio_o};
    sck = 1'b1;
    clk_n(HP);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    logic [3:0] pv;
    for (int i = 0; i < n; i++) slot(lsb_mode ? w[i] : w[n-1-i], pv);
  endtask

  task automatic xfer_begin();
    cs_n = 1'b0;
    clk_n(HP);
  endtask

  task automatic xfer_end();
    clk_n(HP);
    cs_n = 1'b1;
    clk_n(3 * HP);
  endtask

  task automatic wr(input logic [12:0] a, input logic [1:0] len, input int n,
                    input logic [63:0] d);
    xfer_begin();
    send_bits({1'b0, len, a}, 16);
    for (int k = 0; k < n; k++) send_bits({8'h00, d[8*k +: 8]}, 8);
    xfer_end();
  endtask

  task automatic rd(input logic [12:0] a, input logic [1:0] len, input int n,
                    output logic [31:0] got, output int oe_bad);
    logic [3:0] pv;
    got = '0;
    oe_bad = 0;
    xfer_begin();
    send_bits({1'b1, len, a}, 16);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        slot(1'b0, pv);
        if (sdo_mode) begin
          if (!(pv[3] && !pv[1])) oe_bad++;
          got[8*k + (lsb_mode ? i : 7-i)] = pv[2];
        end else begin
          if (!(pv[1] && !pv[3])) oe_bad++;
          got[8*k + (lsb_mode ? i : 7-i)] = pv[0];
        end
      end
    end
    xfer_end();
  endtask

  task automatic t_reset();
    logic [31:0] g; int bad;
    check("R4 reset sdio_oe", sdio_oe, 0);
    check("R4 reset sdo_oe", sdo_oe, 0);
    check("R10 reset a_count", a_count, 0);
    check("R10 reset b_count", b_count, 0);
    check("R11 reset lor_en", lor_en, 0);
    check("R11 reset lock_wait", lock_wait, 3);
    rd(13'h0, 2'b00, 1, g, bad);
    check("R8 reset cfg byte", g, 32'h18);
    check("R4 reset read oe", bad, 0);
  endtask

  task automatic t_single();
    logic [31:0] g; int bad;
    wr(13'h4, 2'b00, 1, 64'h2A);
    check("R1 write a_count", a_count, 6'h2A);
    rd(13'h4, 2'b00, 1, g, bad);
    check("R1 read a_count", g, 32'h2A);
    wr(13'h4, 2'b00, 1, 64'hFF);
    check("R10 a_count width", a_count, 6'h3F);
    rd(13'h4, 2'b00, 1, g, bad);
    check("R10 a_count unused bits", g, 32'h3F);
  endtask

  task automatic t_msb_multi();
    logic [31:0] g; int bad;
    wr(13'h6, 2'b01, 2, 64'h1234);
    check("R2 decrement write b_count", b_count, 13'h1234);
    rd(13'h7, 2'b10, 3, g, bad);
    check("R2 decrement read 7,6,5", g, 32'h123400);
    check("R4 sdio routing", bad, 0);
  endtask

  task automatic t_monitor();
    logic [31:0] g; int bad;
    wr(13'h7, 2'b00, 1, 64'h64);
    check("R11 lor_en set", lor_en, 1);
    check("R11 lock_wait code 11", lock_wait, 24);
    wr(13'h7, 2'b00, 1, 64'hFF);
    rd(13'h7, 2'b00, 1, g, bad);
    check("R11 unused bits read 0", g, 32'h64);
    wr(13'h7, 2'b00, 1, 64'h20);
    check("R11 lor_en clear", lor_en, 0);
    check("R11 lock_wait code 01", lock_wait, 6);
    wr(13'h7, 2'b00, 1, 64'h40);
    check("R11 lock_wait code 10", lock_wait, 12);
  endtask

  task automatic t_reserved();
    logic [31:0] g; int bad;
    wr(13'h2, 2'b00, 1, 64'hFF);
    wr(13'h100, 2'b00, 1, 64'hAA);
    check("R7 a_count untouched", a_count, 6'h3F);
    check("R7 b_count untouched", b_count, 13'h1234);
    check("R7 lock_wait untouched", lock_wait, 12);
    rd(13'h2, 2'b00, 1, g, bad);
    check("R7 read 0x02", g, 0);
    rd(13'h100, 2'b00, 1, g, bad);
    check("R7 read 0x100", g, 0);
  endtask

  task automatic t_count();
    wr(13'h5, 2'b00, 2, 64'h1107);
    check("R12 first byte lands", b_count, 13'h0734);
    check("R12 extra byte ignored", a_count, 6'h3F);
  endtask

  task automatic t_sdo_pin();
    logic [31:0] g; int bad;
    wr(13'h0, 2'b00, 1, 64'h80);
    sdo_mode = 1;
    rd(13'h0, 2'b00, 1, g, bad);
    check("R8 upper copy sets output pin", g, 32'h99);
    check("R4 sdo routing", bad, 0);
    rd(13'h4, 2'b00, 1, g, bad);
    check("R4 sdo data", g, 32'h3F);
  endtask

  task automatic t_soft_reset();
    logic [31:0] g; int bad;
    wr(13'h0, 2'b00, 1, 64'h04);
    sdo_mode = 0;
    check("R6 a_count default", a_count, 0);
    check("R6 b_count default", b_count, 0);
    check("R6 lock_wait default", lock_wait, 3);
    rd(13'h0, 2'b00, 1, g, bad);
    check("R6 cfg default, reset bit clear", g, 32'h18);
    check("R6 sdio routing restored", bad, 0);
    wr(13'h4, 2'b00, 1, 64'h05);
    wr(13'h0, 2'b00, 1, 64'h20);
    check("R6 upper copy resets", a_count, 0);
  endtask

  task automatic t_lsb();
    logic [31:0] g; int bad;
    wr(13'h0, 2'b00, 1, 64'h40);
    lsb_mode = 1;
    wr(13'h5, 2'b01, 2, 64'hBC0A);
    check("R3 increment write b_count", b_count, 13'h0ABC);
    rd(13'h4, 2'b10, 3, g, bad);
    check("R3 increment read 4,5,6", g, 32'hBC0A00);
    rd(13'h0, 2'b00, 1, g, bad);
    check("R8 upper copy sets lsb", g, 32'h5A);
  endtask

  task automatic t_order_change();
    logic [31:0] g; int bad;
    wr(13'h0, 2'b11, 5, 64'h01_FF_FF_FF_00);
    check("R9 same transfer keeps lsb order", a_count, 6'h01);
    lsb_mode = 0;
    rd(13'h0, 2'b00, 1, g, bad);
    check("R9 next transfer msb", g, 32'h18);
  endtask

  task automatic t_abort();
    logic [31:0] g; int bad;
    logic [3:0] pv;
    xfer_begin();
    send_bits(16'h0004 >> 4, 12);
    xfer_end();
    wr(13'h4, 2'b00, 1, 64'h15);
    check("R5 fresh instruction after abort", a_count, 6'h15);
    xfer_begin();
    send_bits({1'b1, 2'b00, 13'h4}, 16);
    slot(1'b0, pv);
    check("R5 read drives before abort", pv[1], 1);
    slot(1'b0, pv);
    cs_n = 1'b1;
    clk_n(HP);
    check("R5 abort releases sdio", sdio_oe, 0);
    check("R5 abort releases sdo", sdo_oe, 0);
    clk_n(2 * HP);
    rd(13'h4, 2'b00, 1, g, bad);
    check("R5 read after abort", g, 32'h15);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdio_i = 1'b0;
    clk_n(5);
    rst_n = 1'b1;
    clk_n(10);
    fork
      begin
        t_reset();
        t_single();
        t_msb_multi();
        t_monitor();
        t_reserved();
        t_count();
        t_sdo_pin();
        t_soft_reset();
        t_lsb();
        t_order_change();
        t_abort();
      end
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule